// File: doc/BRIEF.md
# Sum-of-Products Logic Array

This block is the programmable core of a small logic device. Twenty array inputs are each offered in true and inverted form, which gives forty columns. Sixty-four product terms each AND together whichever columns their connection pattern selects. The terms form eight groups of eight, one group per output, and the terms of each group are ORed into that output's sum. The array inputs come from three places: dedicated input pins, two dual-use pins (the pins a device would otherwise use as clock and global enable), and eight feedback values supplied by the caller, one per output.

The connection pattern holds one bit per array cell, 2560 bits in all. It is captured together with two mode controls while reset is asserted and is then held for as long as reset stays released. The first mode control, registered mode, removes the two dual-use pins from the array. In that mode every column fed by a dual-use pin reads as though the pin were LOW. The second, a per-output enable-term select, takes the last term of that output's group out of the sum and presents it on a separate output, where it can serve as the output's enable. Every product term, sum and enable term follows the inputs combinationally, in the same cycle.

Top module: `pla_sop_array`

## Requirements
- R1: The connection pattern, registered mode and enable-term selects are captured on every rising clock edge while rst_n is low. While rst_n is high, changes on the configuration inputs have no effect on any output.
- R2: A product term with no connected cells evaluates to 1 for every input value.
- R3: A product term that connects both the true and the inverted column of the same input evaluates to 0 for every input value.
- R4: An input connected through its inverted column makes the term true when that input is 0. Connected through its true column, it makes the term true when the input is 1.
- R5: A product term is the AND of all its connected columns.
- R6: When an output's enable-term select is 0, its sum is the OR of all eight terms of its group, and its enable-term output is 0.
- R7: When an output's enable-term select is 1, its sum is the OR of terms 0 to 6 of its group only. The group's term 7 appears on that output's enable-term bit.
- R8: With registered mode 0, the two dual-use pins drive array inputs 10 and 11 like any other input.
- R9: With registered mode 1, array inputs 10 and 11 read as 0 whatever the dual-use pins carry.
- R10: Feedback value k drives array input 12+k.
- R11: Mapping. Array input i is dedicated pin i for i from 0 to 9. Configuration bit t*40+2*i connects the true column of input i to term t, and bit t*40+2*i+1 connects its inverted column. Output k owns terms 8k to 8k+7. term_o[t] shows the value of term t.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; configuration is captured on its rising edge |
| rst_n | input | 1 | Active-low reset; configuration loads while it is low |
| cfg_cells_i | input | 2560 | Connection pattern, one bit per array cell, 1 = connected |
| cfg_regmode_i | input | 1 | Registered mode; 1 removes the dual-use pins from the array |
| cfg_pten_i | input | 8 | Per-output select taking term 7 of the group as an enable term |
| ded_i | input | 10 | Dedicated array input pins |
| dual_i | input | 2 | Dual-use pins (array inputs 10 and 11) |
| fb_i | input | 8 | Per-output feedback values (array inputs 12 to 19) |
| term_o | output | 64 | Value of every product term |
| sum_o | output | 8 | Per-output OR sum |
| oe_term_o | output | 8 | Per-output enable term, 0 when not selected |

## Verification
The bench targets four corner cases.

- Empty terms: a design that reduces an empty term to 0 instead of 1 would show an all-zero sum_o right after a blank configuration.
- Contradictory terms: these must stay low under every input pattern. A design that left them high would keep sums stuck at 1.
- Enable-term selection: the bench checks that term 7 leaves the sum when its select is set. A design that still ORed it in would raise the sum whenever the enable term fires.
- Dual-use pins in registered mode: a design that let them through would make those sums follow the pins.

The bench also changes every configuration input after reset is released and checks that no output moves. An array that read its pattern live would show the new pattern at once.

// File: rtl/pla_pkg.sv
package pla_pkg;

  // Polarity of a column within an input's column pair.
  typedef enum logic {
    POL_TRUE = 1'b0,
    POL_COMP = 1'b1
  } pol_e;

  // Column index of input idx in the given polarity.
  function automatic int col_of(input int idx, input pol_e pol);
    return 2 * idx + ((pol == POL_COMP) ? 1 : 0);
  endfunction

  // Flat configuration bit for (term, column).
  function automatic int cell_of(input int term, input int col, input int ncol);
    return term * ncol + col;
  endfunction

endpackage

// File: rtl/pla_cfg_store.sv
module pla_cfg_store #(
  parameter int NCELL = 2560,
  parameter int N_OUT = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCELL-1:0] cells_i,
  input  logic             regmode_i,
  input  logic [N_OUT-1:0] pten_i,
  output logic [NCELL-1:0] cells_q,
  output logic             regmode_q,
  output logic [N_OUT-1:0] pten_q
);

  // Load while reset is held, freeze afterwards.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cells_q   <= cells_i;
      regmode_q <= regmode_i;
      pten_q    <= pten_i;
    end
  end

  // R1: configuration holds still once reset is released
  p_cfg_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ($stable(cells_q) && $stable(regmode_q) && $stable(pten_q)));

endmodule

// File: rtl/pla_col_drive.sv
module pla_col_drive
  import pla_pkg::*;
#(
  parameter int N_DED  = 10,
  parameter int N_DUAL = 2,
  parameter int N_OUT  = 8,
  localparam int N_IN  = N_DED + N_DUAL + N_OUT,
  localparam int NCOL  = 2 * N_IN
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_DED-1:0]  ded_i,
  input  logic [N_DUAL-1:0] dual_i,
  input  logic [N_OUT-1:0]  fb_i,
  input  logic              regmode,
  output logic [NCOL-1:0]   cols_o
);

  // Array input values before the true/inverted split.
  logic [N_IN-1:0] in_val;

  for (genvar i = 0; i < N_IN; i++) begin : g_in
    if (i < N_DED) begin : g_ded
      assign in_val[i] = ded_i[i];
    end else if (i < N_DED + N_DUAL) begin : g_dual
      // Registered mode removes the dual-use pin: reads as LOW.
      assign in_val[i] = dual_i[i-N_DED] & ~regmode;
    end else begin : g_fb
      assign in_val[i] = fb_i[i-N_DED-N_DUAL];
    end
    assign cols_o[col_of(i, POL_TRUE)] = in_val[i];
    assign cols_o[col_of(i, POL_COMP)] = ~in_val[i];
  end

  for (genvar j = 0; j < N_DUAL; j++) begin : g_dual_chk
    // R9: dual-use columns read as a LOW pin in registered mode
    p_dual_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
      regmode |-> (cols_o[2*(N_DED+j)] == 1'b0 && cols_o[2*(N_DED+j)+1] == 1'b1));
    // R8: dual-use pins reach the array in combinational mode
    p_dual_live_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !regmode |-> (cols_o[2*(N_DED+j)] == dual_i[j]));
  end

endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane #(
  parameter int NCOL  = 40,
  parameter int NTERM = 64,
  localparam int NCELL = NCOL * NTERM
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCELL-1:0] cells,
  input  logic [NCOL-1:0]  cols,
  output logic [NTERM-1:0] terms
);

  // True when some input has both its columns connected.
  function automatic logic has_conflict(input logic [NCOL-1:0] c);
    logic hit;
    hit = 1'b0;
    for (int i = 0; i < NCOL / 2; i++) begin
      hit = hit | (c[2*i] & c[2*i+1]);
    end
    return hit;
  endfunction

  for (genvar t = 0; t < NTERM; t++) begin : g_term
    logic [NCOL-1:0] row;
    assign row = cells[t*NCOL +: NCOL];
    // A column counts only where the cell is connected.
    assign terms[t] = &(~row | cols);

    // R2: a term with no connections is HIGH
    p_blank_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (row == '0) |-> terms[t]);
    // R3: a term holding both polarities of one input is LOW
    p_conflict_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
      has_conflict(row) |-> !terms[t]);
  end

endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
  parameter int N_OUT = 8,
  parameter int TPO   = 8,
  localparam int NTERM = N_OUT * TPO,
  localparam int EN    = TPO - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NTERM-1:0] terms,
  input  logic [N_OUT-1:0] pten,
  output logic [N_OUT-1:0] sum_o,
  output logic [N_OUT-1:0] oe_term_o
);

  // OR of a group, leaving out the last term when it is taken as an enable.
  function automatic logic fold_group(input logic [TPO-1:0] g, input logic steal);
    return (|g[EN-1:0]) | (g[EN] & ~steal);
  endfunction

  for (genvar k = 0; k < N_OUT; k++) begin : g_grp
    logic [TPO-1:0] grp;
    assign grp          = terms[k*TPO +: TPO];
    assign sum_o[k]     = fold_group(grp, pten[k]);
    assign oe_term_o[k] = grp[EN] & pten[k];

    // R7: a stolen enable term never reaches the sum
    p_stolen_term_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (pten[k] && grp[EN-1:0] == '0) |-> !sum_o[k]);
    // R6: enable-term output idles at 0 when not selected
    p_oe_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !pten[k] |-> !oe_term_o[k]);
    // R6: the last term still counts toward an ordinary sum
    p_last_counts_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!pten[k] && grp[EN]) |-> sum_o[k]);
  end

endmodule

// File: rtl/pla_sop_array.sv
module pla_sop_array
  import pla_pkg::*;
#(
  parameter int N_DED  = 10,
  parameter int N_DUAL = 2,
  parameter int N_OUT  = 8,
  parameter int TPO    = 8,
  localparam int N_IN  = N_DED + N_DUAL + N_OUT,
  localparam int NCOL  = 2 * N_IN,
  localparam int NTERM = N_OUT * TPO,
  localparam int NCELL = NTERM * NCOL
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCELL-1:0]  cfg_cells_i,
  input  logic              cfg_regmode_i,
  input  logic [N_OUT-1:0]  cfg_pten_i,
  input  logic [N_DED-1:0]  ded_i,
  input  logic [N_DUAL-1:0] dual_i,
  input  logic [N_OUT-1:0]  fb_i,
  output logic [NTERM-1:0]  term_o,
  output logic [N_OUT-1:0]  sum_o,
  output logic [N_OUT-1:0]  oe_term_o
);

  logic [NCELL-1:0] cells_q;
  logic             regmode_q;
  logic [N_OUT-1:0] pten_q;
  logic [NCOL-1:0]  cols;
  logic [NTERM-1:0] terms;

  pla_cfg_store #(.NCELL(NCELL), .N_OUT(N_OUT)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .cells_i   (cfg_cells_i),
    .regmode_i (cfg_regmode_i),
    .pten_i    (cfg_pten_i),
    .cells_q   (cells_q),
    .regmode_q (regmode_q),
    .pten_q    (pten_q)
  );

  pla_col_drive #(.N_DED(N_DED), .N_DUAL(N_DUAL), .N_OUT(N_OUT)) u_cols (
    .clk     (clk),
    .rst_n   (rst_n),
    .ded_i   (ded_i),
    .dual_i  (dual_i),
    .fb_i    (fb_i),
    .regmode (regmode_q),
    .cols_o  (cols)
  );

  pla_and_plane #(.NCOL(NCOL), .NTERM(NTERM)) u_and (
    .clk   (clk),
    .rst_n (rst_n),
    .cells (cells_q),
    .cols  (cols),
    .terms (terms)
  );

  pla_or_plane #(.N_OUT(N_OUT), .TPO(TPO)) u_or (
    .clk       (clk),
    .rst_n     (rst_n),
    .terms     (terms),
    .pten      (pten_q),
    .sum_o     (sum_o),
    .oe_term_o (oe_term_o)
  );

  assign term_o = terms;

  // R11: every sum bit is backed by at least one high term of its own group
  for (genvar k = 0; k < N_OUT; k++) begin : g_map_chk
    p_sum_source_r11: assert property (@(posedge clk) disable iff (!rst_n)
      sum_o[k] |-> (term_o[k*TPO +: TPO] != '0));
  end

endmodule

// File: tb/tb_pla_sop_array.sv
module tb_pla_sop_array;
  localparam int CLK_PERIOD = 10;
  localparam int NI = 20;
  localparam int NC = 40;
  localparam int NT = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NC*NT-1:0] cfg_cells_i = '0;
  logic cfg_regmode_i = 1'b0;
  logic [7:0] cfg_pten_i = '0;
  logic [9:0] ded_i = '0;
  logic [1:0] dual_i = '0;
  logic [7:0] fb_i = '0;
  logic [63:0] term_o;
  logic [7:0] sum_o, oe_term_o;

  logic [NC*NT-1:0] cells;
  logic [NC*NT-1:0] cells_live;
  logic regmode_live;
  logic [7:0] pten_live;
  int checks = 0;
  int fails = 0;

  pla_sop_array dut (
    .clk(clk), .rst_n(rst_n), .cfg_cells_i(cfg_cells_i), .cfg_regmode_i(cfg_regmode_i),
    .cfg_pten_i(cfg_pten_i), .ded_i(ded_i), .dual_i(dual_i), .fb_i(fb_i),
    .term_o(term_o), .sum_o(sum_o), .oe_term_o(oe_term_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 20000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic conn(input int t, input int i, input int pol);
    cells[t*NC + 2*i + pol] = 1'b1;
  endtask

  task automatic kill(input int t);
    conn(t, 9, 0);
    conn(t, 9, 1);
  endtask

  task automatic load(input logic rm, input logic [7:0] pt);
    @(negedge clk);
    rst_n = 1'b0;
    cfg_cells_i = cells;
    cfg_regmode_i = rm;
    cfg_pten_i = pt;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    cells_live = cells;
    regmode_live = rm;
    pten_live = pt;
  endtask

  task automatic drive(input logic [9:0] d, input logic [1:0] u, input logic [7:0] f);
    @(negedge clk);
    ded_i = d;
    dual_i = u;
    fb_i = f;
    #1;
  endtask

  // Independent reference: a term fails when a connected column disagrees.
  function automatic logic [63:0] model_terms();
    logic [NI-1:0] v;
    logic [63:0] r;
    v = {fb_i, dual_i, ded_i};
    if (regmode_live) v[11:10] = 2'b00;
    for (int t = 0; t < NT; t++) begin
      r[t] = 1'b1;
      for (int i = 0; i < NI; i++) begin
        if (cells_live[t*NC + 2*i] && !v[i]) r[t] = 1'b0;
        if (cells_live[t*NC + 2*i + 1] && v[i]) r[t] = 1'b0;
      end
    end
    return r;
  endfunction

  function automatic logic [7:0] model_sums(input logic [63:0] tm);
    logic [7:0] s;
    for (int k = 0; k < 8; k++) begin
      s[k] = 1'b0;
      for (int j = 0; j < 8; j++)
        if (!(j == 7 && pten_live[k])) s[k] = s[k] | tm[8*k+j];
    end
    return s;
  endfunction

  task automatic t_blank();
    cells = '0;
    load(1'b0, 8'h00);
    drive(10'h2A5, 2'b10, 8'h3C);
    chk("R2 blank terms", term_o, {64{1'b1}});
    chk("R6 blank sums", {56'd0, sum_o}, 64'hFF);
    chk("R6 idle enable terms", {56'd0, oe_term_o}, 64'h0);
    load(1'b0, 8'hFF);
    drive(10'h000, 2'b00, 8'h00);
    chk("R7 blank sums with enable terms", {56'd0, sum_o}, 64'hFF);
    chk("R7 enable terms high", {56'd0, oe_term_o}, 64'hFF);
  endtask

  task automatic t_contra();
    cells = '0;
    for (int t = 0; t < NT; t++) kill(t);
    conn(5, 0, 0);
    conn(5, 0, 1);
    load(1'b0, 8'h00);
    drive(10'h3FF, 2'b11, 8'hFF);
    chk("R3 contradictory terms high inputs", term_o, 64'h0);
    drive(10'h000, 2'b00, 8'h00);
    chk("R3 contradictory terms low inputs", term_o, 64'h0);
    chk("R3 sums low", {56'd0, sum_o}, 64'h0);
  endtask

  task automatic t_and_pol();
    cells = '0;
    conn(0, 0, 0);
    conn(0, 1, 1);
    for (int t = 1; t < 8; t++) kill(t);
    load(1'b0, 8'h00);
    for (int c = 0; c < 4; c++) begin
      drive(10'(c), 2'b00, 8'h00);
      chk("R4 R5 true/inverted AND term0", {63'd0, term_o[0]}, {63'd0, c == 1});
      chk("R11 group0 sum", {63'd0, sum_o[0]}, {63'd0, c == 1});
    end
  endtask

  task automatic t_or();
    cells = '0;
    conn(8, 2, 0);
    conn(9, 3, 0);
    for (int t = 10; t < 16; t++) kill(t);
    load(1'b0, 8'h00);
    for (int c = 0; c < 4; c++) begin
      drive(10'(c << 2), 2'b00, 8'h00);
      chk("R6 group1 OR", {63'd0, sum_o[1]}, {63'd0, c != 0});
    end
  endtask

  task automatic t_pten();
    cells = '0;
    for (int t = 16; t < 23; t++) kill(t);
    conn(23, 4, 0);
    for (int t = 24; t < 31; t++) kill(t);
    conn(31, 4, 0);
    load(1'b0, 8'b0000_0100);
    drive(10'h010, 2'b00, 8'h00);
    chk("R7 stolen term kept out of sum2", {63'd0, sum_o[2]}, 64'd0);
    chk("R7 enable term2 high", {63'd0, oe_term_o[2]}, 64'd1);
    chk("R6 ordinary sum3 uses term7", {63'd0, sum_o[3]}, 64'd1);
    chk("R6 enable term3 idle", {63'd0, oe_term_o[3]}, 64'd0);
    drive(10'h000, 2'b00, 8'h00);
    chk("R7 enable term2 low", {56'd0, oe_term_o}, 64'd0);
  endtask

  task automatic t_dual();
    cells = '0;
    conn(32, 10, 0);
    for (int t = 33; t < 40; t++) kill(t);
    conn(40, 11, 1);
    for (int t = 41; t < 48; t++) kill(t);
    load(1'b0, 8'h00);
    drive(10'h000, 2'b01, 8'h00);
    chk("R8 dual pins live 01", {62'd0, sum_o[5:4]}, 64'b11);
    drive(10'h000, 2'b10, 8'h00);
    chk("R8 dual pins live 10", {62'd0, sum_o[5:4]}, 64'b00);
    load(1'b1, 8'h00);
    drive(10'h000, 2'b01, 8'h00);
    chk("R9 dual pins forced low 01", {62'd0, sum_o[5:4]}, 64'b10);
    drive(10'h000, 2'b11, 8'h00);
    chk("R9 dual pins forced low 11", {62'd0, sum_o[5:4]}, 64'b10);
  endtask

  task automatic t_fb();
    cells = '0;
    conn(48, 19, 0);
    conn(48, 12, 1);
    for (int t = 49; t < 56; t++) kill(t);
    load(1'b0, 8'h00);
    drive(10'h000, 2'b00, 8'h80);
    chk("R10 feedback 80", {63'd0, sum_o[6]}, 64'd1);
    drive(10'h000, 2'b00, 8'h81);
    chk("R10 feedback 81", {63'd0, sum_o[6]}, 64'd0);
    drive(10'h3FF, 2'b11, 8'h00);
    chk("R10 feedback 00", {63'd0, sum_o[6]}, 64'd0);
  endtask

  task automatic t_hold();
    cells = '0;
    for (int t = 0; t < NT; t++) if (t != 7) kill(t);
    load(1'b0, 8'h00);
    @(negedge clk);
    cfg_cells_i = '0;
    cfg_pten_i = 8'hFF;
    cfg_regmode_i = 1'b1;
    repeat (3) @(posedge clk);
    drive(10'h155, 2'b11, 8'h0F);
    chk("R1 pattern held after reset", term_o, 64'h80);
    chk("R1 selects held after reset sum", {56'd0, sum_o}, 64'h01);
    chk("R1 selects held after reset enable", {56'd0, oe_term_o}, 64'h00);
  endtask

  task automatic t_mixed();
    logic [31:0] lf;
    logic [63:0] tm;
    lf = 32'hACE1_2468;
    cells = '0;
    for (int b = 0; b < NC*NT; b++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      cells[b] = (lf[3:0] == 4'h0);
    end
    for (int m = 0; m < 2; m++) begin
      load(m[0], 8'hA5);
      for (int p = 0; p < 12; p++) begin
        lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
        drive(lf[9:0] | lf[29:20], lf[11:10], lf[19:12] | lf[27:20]);
        tm = model_terms();
        chk("R11 mixed terms", term_o, tm);
        chk("R11 mixed sums", {56'd0, sum_o}, {56'd0, model_sums(tm)});
        chk("R11 mixed enable terms", {56'd0, oe_term_o}, {56'd0, tm[63:56] & 8'h0 | {tm[63], tm[55], tm[47], tm[39], tm[31], tm[23], tm[15], tm[7]} & pten_live});
      end
    end
  endtask

  initial begin
    t_blank();
    t_contra();
    t_and_pol();
    t_or();
    t_pten();
    t_dual();
    t_fb();
    t_hold();
    t_mixed();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule